// File: doc/BRIEF.md
# ADC Conversion Control and Status Unit

This block sits between a small register bus and a successive-approximation converter core. Software writes a command byte to start or stop conversions, then polls a status byte or waits for the interrupt output. The converter core is modelled as a counter with a fixed latency. A programmable count groups conversions into one sequence. A DMA request is raised for every result, and the acknowledge that comes back is tracked.

Two one-shot command bits clear themselves on the clock after the write. A start launches a sequence only when the converter is enabled and idle. A stop lets the conversion in flight finish and then ends the sequence. The status byte holds read-only state flags and three sticky interrupt flags that are cleared by writing 1. The interrupt output is the OR of the three sticky flags. An external trigger input sets its own flag and launches a sequence in the same way a start command does.

Top module: `adc_ctl_top`

## Requirements
- R1: The command byte (address 0) has stop at bit 7 and start at bit 1. Both reset to 0, and each clears itself one clock after the write that set it, so a read issued two clocks after the write returns 0.
- R2: A start is ignored when `adc_en` is 0. No strobe is issued, busy stays low, and the request is not held for later.
- R3: With `adc_en` at 1 and the unit idle, a start write accepted on edge E0 produces a one-cycle `soc` strobe and raises busy on edge E1. A single conversion ends on edge E1+14 (a length of CONV_CYC clocks).
- R4: Status bit 7 (end of conversion) is set when a conversion ends. It is cleared by the conversion-start strobe, not by the start write.
- R5: `seq_len` conversions form one sequence, and a value of 0 counts as 1. Busy stays high from the first strobe until the last conversion ends. Each later strobe follows the previous end by one clock. Status bit 0 is set at every conversion end, and status bit 2 is set only when the final conversion of the sequence ends.
- R6: A stop during a sequence lets the current conversion finish. Busy then falls, no further strobe is issued, and status bit 2 is not set.
- R7: Status layout (address 1): bit 7 end of conversion, bit 6 busy, bit 5 DMA overrun, bit 4 DMA done, bit 3 trigger flag, bit 2 end of sequence, bit 0 conversion flag. Bit 1 reads 0. Writing 1 to bit 3, 2 or 0 clears that flag, but a set event in the same cycle wins. Read data appears one clock after `rd_en`.
- R8: `dma_req` rises at each conversion end and holds until `dma_ack` arrives. An acknowledge while the request is high drops the request and sets status bit 4.
- R9: Status bit 5 is set when a conversion ends while the previous request is still unacknowledged. It does not drive `irq`. Bits 5 and 4 clear when a new sequence launches.
- R10: `irq` is the OR of status bits 3, 2 and 0.
- R11: A one-cycle `trig_in` pulse sets status bit 3. When the unit is enabled and idle, the same pulse launches a sequence with its strobe on the same edge.
- R12: A start written while busy is ignored: no extra strobe, and the sequence ends as it would have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address (0 command, 1 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| adc_en | input | 1 | Converter enable |
| seq_len | input | SEQ_W | Conversions per sequence (0 means 1) |
| trig_in | input | 1 | External trigger pulse |
| soc | output | 1 | Conversion-start strobe to the core |
| conv_busy | output | 1 | Sequence in progress |
| dma_req | output | 1 | DMA request for the latest result |
| dma_ack | input | 1 | DMA acknowledge |
| irq | output | 1 | Interrupt output |

## Verification
A start write on edge E0 gives `soc` and busy on E1, and the conversion ends on E1+14. On that end edge the status flags, `dma_req` and `irq` change. In a sequence, each later strobe follows the previous end by one edge, so conversions repeat every 15 clocks. Read data reflects the state before the read edge and is valid just after it. The bench advances time one falling edge at a time, counts these edges from each stimulus, and queues each expectation at the falling edge after the edge on which the result is due. The monitor compares those expectations against the ports.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int REG_CMD  = 0;
  localparam int REG_STAT = 1;
  localparam int CMD_STOP  = 7;
  localparam int CMD_START = 1;
  localparam int ST_EOC  = 7;
  localparam int ST_BUSY = 6;
  localparam int ST_OVR  = 5;
  localparam int ST_DONE = 4;
  localparam int ST_TRIG = 3;
  localparam int ST_EOS  = 2;
  localparam int ST_CONV = 0;

  typedef struct packed {
    logic soc;
    logic conv_end;
    logic seq_end;
    logic launch;
  } adc_evt_t;
endpackage

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq #(
  parameter int CONV_CYC = 14,
  parameter int SEQ_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_req,
  input  logic             stop_req,
  input  logic             adc_en,
  input  logic [SEQ_W-1:0] seq_len,
  output logic             busy,
  output logic             eoc_flag,
  output adc_ctl_pkg::adc_evt_t evt
);
  localparam int CNT_W = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [SEQ_W-1:0] idx, num;
  logic             gap, stop_pend, soc_q;
  logic             conv_end, last, launch;

  assign launch   = !busy && go_req && adc_en;
  assign conv_end = busy && !gap && (cnt == CNT_LAST);
  assign last     = (idx == num - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cnt <= '0; idx <= '0; num <= '0;
      gap <= 1'b0; stop_pend <= 1'b0; soc_q <= 1'b0; eoc_flag <= 1'b0;
    end else begin
      soc_q <= 1'b0;
      if (!busy) begin
        if (launch) begin
          busy <= 1'b1; soc_q <= 1'b1; cnt <= '0; idx <= '0;
          num <= (seq_len == '0) ? SEQ_W'(1) : seq_len;
          stop_pend <= 1'b0; gap <= 1'b0; eoc_flag <= 1'b0;
        end
      end else if (gap) begin
        gap <= 1'b0; soc_q <= 1'b1; cnt <= '0; idx <= idx + 1'b1;
        eoc_flag <= 1'b0;
        if (stop_req) stop_pend <= 1'b1;
      end else if (conv_end) begin
        eoc_flag <= 1'b1;
        if (last || stop_pend || stop_req) busy <= 1'b0;
        else gap <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (stop_req) stop_pend <= 1'b1;
      end
    end
  end

  assign evt.soc      = soc_q;
  assign evt.conv_end = conv_end;
  assign evt.seq_end  = conv_end && last;
  assign evt.launch   = launch;

  p_soc_pulse_r3: assert property (@(posedge clk) disable iff (rst) soc_q |=> !soc_q);
  p_start_needs_en_r2: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(adc_en));
  p_soc_clears_eoc_r4: assert property (@(posedge clk) disable iff (rst) soc_q |-> !eoc_flag);
  p_stop_ends_r6: assert property (@(posedge clk) disable iff (rst) (conv_end && stop_pend) |=> !busy);
endmodule

// File: rtl/adc_ctl_dma.sv
module adc_ctl_dma (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic conv_end,
  input  logic dma_ack,
  output logic req,
  output logic done,
  output logic ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0; done <= 1'b0; ovr <= 1'b0;
    end else begin
      if (launch) begin
        done <= 1'b0; ovr <= 1'b0;
      end
      if (req && dma_ack) done <= 1'b1;
      if (conv_end) begin
        req <= 1'b1;
        if (req && !dma_ack) ovr <= 1'b1;
      end else if (dma_ack) begin
        req <= 1'b0;
      end
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst) (req && !dma_ack) |=> req);
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (rst) $rose(ovr) |-> $past(req));
endmodule

// File: rtl/adc_ctl_regs.sv
module adc_ctl_regs #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              eoc_flag,
  input  logic              dma_done,
  input  logic              dma_ovr,
  input  logic              trig_in,
  input  adc_ctl_pkg::adc_evt_t evt,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic [7:0]        rdata,
  output logic              irq
);
  import adc_ctl_pkg::*;

  logic wr_cmd, wr_stat;
  logic f_trig, f_eos, f_conv;
  logic n_trig, n_eos, n_conv;
  logic [7:0] stat_byte, cmd_byte;
  logic unused_wbits;

  assign unused_wbits = ^wdata[6:4];
  assign wr_cmd  = wr_en && (addr == ADDR_W'(REG_CMD));
  assign wr_stat = wr_en && (addr == ADDR_W'(REG_STAT));

  assign n_trig = trig_in      | (f_trig & !(wr_stat & wdata[ST_TRIG]));
  assign n_eos  = evt.seq_end  | (f_eos  & !(wr_stat & wdata[ST_EOS]));
  assign n_conv = evt.conv_end | (f_conv & !(wr_stat & wdata[ST_CONV]));

  always_comb begin
    stat_byte = '0;
    stat_byte[ST_EOC]  = eoc_flag;
    stat_byte[ST_BUSY] = busy;
    stat_byte[ST_OVR]  = dma_ovr;
    stat_byte[ST_DONE] = dma_done;
    stat_byte[ST_TRIG] = f_trig;
    stat_byte[ST_EOS]  = f_eos;
    stat_byte[ST_CONV] = f_conv;
    cmd_byte = '0;
    cmd_byte[CMD_STOP]  = stop_cmd;
    cmd_byte[CMD_START] = start_cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_cmd <= 1'b0; stop_cmd <= 1'b0;
      f_trig <= 1'b0; f_eos <= 1'b0; f_conv <= 1'b0;
      irq <= 1'b0; rdata <= '0;
    end else begin
      start_cmd <= wr_cmd && wdata[CMD_START];
      stop_cmd  <= wr_cmd && wdata[CMD_STOP];
      f_trig <= n_trig; f_eos <= n_eos; f_conv <= n_conv;
      irq <= n_trig | n_eos | n_conv;
      if (rd_en) rdata <= (addr == ADDR_W'(REG_CMD)) ? cmd_byte : stat_byte;
    end
  end

  p_cmd_from_write_r1: assert property (@(posedge clk) disable iff (rst) (start_cmd || stop_cmd) |-> $past(wr_en));
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst) evt.conv_end |=> f_conv);
  p_bit1_zero_r7: assert property (@(posedge clk) disable iff (rst) (rd_en && addr == ADDR_W'(REG_STAT)) |=> (rdata[1] == 1'b0));
  p_irq_or_r10: assert property (@(posedge clk) disable iff (rst) irq == (f_trig | f_eos | f_conv));
endmodule

// File: rtl/adc_ctl_top.sv
module adc_ctl_top #(
  parameter int ADDR_W   = 2,
  parameter int SEQ_W    = 4,
  parameter int CONV_CYC = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              adc_en,
  input  logic [SEQ_W-1:0]  seq_len,
  input  logic              trig_in,
  output logic              soc,
  output logic              conv_busy,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic              irq
);
  adc_ctl_pkg::adc_evt_t evt;
  logic start_cmd, stop_cmd, eoc_flag, dma_done, dma_ovr;

  adc_ctl_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(conv_busy), .eoc_flag(eoc_flag), .dma_done(dma_done),
    .dma_ovr(dma_ovr), .trig_in(trig_in), .evt(evt), .start_cmd(start_cmd),
    .stop_cmd(stop_cmd), .rdata(rdata), .irq(irq)
  );

  adc_ctl_seq #(.CONV_CYC(CONV_CYC), .SEQ_W(SEQ_W)) seq_i (
    .clk(clk), .rst(rst), .go_req(start_cmd | trig_in), .stop_req(stop_cmd),
    .adc_en(adc_en), .seq_len(seq_len), .busy(conv_busy), .eoc_flag(eoc_flag),
    .evt(evt)
  );

  adc_ctl_dma dma_i (
    .clk(clk), .rst(rst), .launch(evt.launch), .conv_end(evt.conv_end),
    .dma_ack(dma_ack), .req(dma_req), .done(dma_done), .ovr(dma_ovr)
  );

  assign soc = evt.soc;

  p_trig_flag_r11: assert property (@(posedge clk) disable iff (rst) trig_in |=> irq);
endmodule

// File: tb/adc_ctl_top_tb_top.sv
module adc_ctl_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, adc_en = 0, trig_in = 0, dma_ack = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [3:0] seq_len = '0;
  logic [7:0] rdata;
  logic soc, conv_busy, dma_req, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];
  event ev_chk;

  always #10 clk = ~clk;

  adc_ctl_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .adc_en(adc_en), .seq_len(seq_len),
    .trig_in(trig_in), .soc(soc), .conv_busy(conv_busy), .dma_req(dma_req),
    .dma_ack(dma_ack), .irq(irq)
  );

  // monitor: pops expectations and compares against ports
  always @(ev_chk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {7'd0, conv_busy};
        2: act = {7'd0, irq};
        3: act = {7'd0, dma_req};
        default: act = {7'd0, soc};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_port(int kind, logic [7:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> ev_chk;
    #1;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    cyc();
    wr_en = 0; wdata = '0;
  endtask

  task automatic bus_rd(logic [1:0] a, logic [7:0] e, string tag);
    rd_en = 1; addr = a;
    cyc();
    rd_en = 0;
    expect_port(0, e, tag);
  endtask

  task automatic ack_pulse();
    dma_ack = 1;
    cyc();
    dma_ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc();
    // reset state
    bus_rd(2'd0, 8'h00, "R1 cmd reset");
    bus_rd(2'd1, 8'h00, "R7 status reset");
    expect_port(2, 0, "R10 irq reset");
    expect_port(1, 0, "R3 busy reset");
    expect_port(3, 0, "R8 req reset");

    // R2: start ignored while disabled
    bus_wr(2'd0, 8'h02);
    cyc();
    expect_port(4, 0, "R2 no soc");
    expect_port(1, 0, "R2 no busy");
    adc_en = 1;
    cyc();
    expect_port(1, 0, "R2 request not held");

    // R3/R5: single conversion, seq_len 0 counts as 1
    seq_len = 0;
    bus_wr(2'd0, 8'h02);
    cyc();
    expect_port(4, 1, "R3 soc strobe");
    expect_port(1, 1, "R3 busy up");
    cyc();
    expect_port(4, 0, "R3 soc one cycle");
    bus_rd(2'd0, 8'h00, "R1 start self cleared");
    cyc(11);
    expect_port(1, 1, "R3 busy before end");
    cyc();
    expect_port(1, 0, "R5 busy down at end");
    expect_port(3, 1, "R8 req at conversion end");
    expect_port(2, 1, "R10 irq from flags");
    bus_rd(2'd1, 8'h85, "R7 status after single");

    // R4: write does not clear eoc, strobe does; R9 overrun
    bus_wr(2'd0, 8'h02);
    bus_rd(2'd1, 8'h85, "R4 eoc kept over start write");
    bus_rd(2'd1, 8'h45, "R4 eoc cleared by strobe");
    cyc(13);
    bus_rd(2'd1, 8'hA5, "R9 overrun set");
    bus_wr(2'd1, 8'h05);
    expect_port(2, 0, "R9 overrun gives no irq");
    bus_rd(2'd1, 8'hA0, "R7 w1c cleared");
    ack_pulse();
    expect_port(3, 0, "R8 req dropped by ack");
    bus_rd(2'd1, 8'hB0, "R8 done set");

    // R5: sequence of three
    seq_len = 3;
    bus_wr(2'd0, 8'h02);
    cyc(15);
    expect_port(3, 1, "R8 req first result");
    expect_port(1, 1, "R5 busy between conversions");
    dma_ack = 1;
    cyc();
    dma_ack = 0;
    expect_port(4, 1, "R5 second strobe");
    expect_port(3, 0, "R8 ack drops req");
    cyc(28);
    expect_port(1, 1, "R5 busy before last end");
    cyc();
    expect_port(1, 0, "R5 busy down after three");
    bus_rd(2'd1, 8'hB5, "R5 status after sequence");
    ack_pulse();
    bus_wr(2'd1, 8'h0D);

    // R6: stop mid sequence
    seq_len = 4;
    bus_wr(2'd0, 8'h02);
    cyc(3);
    bus_wr(2'd0, 8'h80);
    cyc(10);
    expect_port(1, 1, "R6 current conversion runs");
    cyc();
    expect_port(1, 0, "R6 busy falls after stop");
    cyc(20);
    expect_port(1, 0, "R6 no further conversion");
    bus_rd(2'd1, 8'h81, "R6 eos not set on stop");
    ack_pulse();
    bus_wr(2'd1, 8'h0D);

    // R12: start while busy
    seq_len = 1;
    bus_wr(2'd0, 8'h02);
    cyc(4);
    bus_wr(2'd0, 8'h02);
    cyc();
    expect_port(4, 0, "R12 no extra strobe");
    cyc(8);
    expect_port(1, 1, "R12 still busy");
    cyc();
    expect_port(1, 0, "R12 ends on time");
    cyc(2);
    expect_port(1, 0, "R12 not restarted");
    ack_pulse();
    bus_wr(2'd1, 8'h0D);
    expect_port(2, 0, "R10 irq cleared");

    // R11: trigger
    trig_in = 1;
    cyc();
    trig_in = 0;
    expect_port(4, 1, "R11 trigger strobe");
    expect_port(2, 1, "R11 trigger irq");
    cyc(14);
    expect_port(1, 0, "R11 conversion done");
    bus_rd(2'd1, 8'h8D, "R11 trigger flag");
    bus_wr(2'd1, 8'h08);
    bus_rd(2'd1, 8'h85, "R7 only trig cleared");
    expect_port(2, 1, "R10 irq from remaining flags");
    bus_wr(2'd1, 8'h05);
    expect_port(2, 0, "R10 irq low with flags clear");

    cyc(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule